// File: doc/BRIEF.md
# Glitch-free gated clock buffer

This block takes a free-running clock or data stream, sampled once per cycle of the system clock. It drives two complementary pairs from it. The first pair is an ungated copy of the input, used for example to close an oscillator feedback loop. The second pair is gated by an enable. The enable passes through a retiming chain and is then applied only while the input sits at the chosen park level. As a result, gating never shortens a pulse, never produces a runt and never adds a count.

Two static selectors shape the gate. One sets which enable level means "pass". The other sets whether the gated pair parks with the true output low or high while disabled. Pulses are measured relative to the park level: a pulse is a run of input samples at the opposite level. When the gate closes during a pulse, that pulse finishes at full width. When the gate opens during a pulse, that pulse is skipped, so the first pulse passed after re-enable is complete.

Top module: `gated_clk_buf`

## Requirements
- R1: `raw_q` equals `din` as sampled at the previous clock edge and `raw_qn` is its inverse, whatever the values of `en_in`, `en_inv_sel` and `park_hi`.
- R2: With `en_inv_sel` = 0, `en_in` = 1 requests pass and `en_in` = 0 requests disable. With `en_inv_sel` = 1, `en_in` = 0 requests pass and `en_in` = 1 requests disable.
- R3: The gate decision made at a clock edge uses the value of `en_in` sampled EN_STAGES edges earlier (default 2).
- R4: While disabled, the gated pair parks at `gate_q` = `park_hi` and `gate_qn` = `!park_hi`. `park_hi` = 0 selects park low and `park_hi` = 1 selects park high. `park_hi` is changed only under reset.
- R5: A disable request seen while the sampled input is at the park level takes effect at once, so the next pulse away from the park level is blocked.
- R6: A disable request seen while the sampled input is away from the park level leaves the gate open until the input returns to the park level, so the current pulse completes at full width.
- R7: A pass request takes effect only while the sampled input is at the park level, so the first gated pulse after re-enable is a complete input pulse.
- R8: `gate_qn` is always the exact inverse of `gate_q`.
- R9: The gated pair stays parked for as long as the disable request holds.
- R10: During synchronous reset, the gate is shut and the outputs read `raw_q` = 0, `raw_qn` = 1, `gate_q` = `park_hi` and `gate_qn` = `!park_hi`.
- R11: Every gated pulse has the same width as the `raw_q` pulse it coincides with, and it ends in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Free-running clock or data input |
| en_in | input | 1 | Gate enable, may be asynchronous |
| en_inv_sel | input | 1 | Selects the active level of `en_in` (1 = active low) |
| park_hi | input | 1 | Selects the disabled level of `gate_q` |
| raw_q | output | 1 | Ungated true output |
| raw_qn | output | 1 | Ungated complement output |
| gate_q | output | 1 | Gated true output |
| gate_qn | output | 1 | Gated complement output |

## Verification
The assertions check on every cycle the properties that hold regardless of the enable:
- the ungated pair tracks the input one cycle later;
- the gated pair stays complementary;
- a gated pulse only begins after the input was at the park level, and ends only when the input returns there.

Only the scenarios can show where the gate is expected to open and close. That depends on the enable polarity, on the retiming latency and on the phase of the enable relative to the input. The bench sweeps both selectors against many pulse shapes and enable phases. It also checks the widths of gated pulses against the ungated pulses.

// File: rtl/gcb_pkg.sv
package gcb_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

  localparam int unsigned GCB_EN_STAGES_DEF = 2;
endpackage

// File: rtl/gcb_en_sync.sv
module gcb_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_raw,
  input  logic inv_sel,
  output logic want_pass
);
  logic en_late;

  generate
    if (STAGES == 0) begin : g_direct
      assign en_late = en_raw;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], en_raw} & {STAGES{1'b1}};
      end
      assign en_late = chain[STAGES-1];
    end
  endgenerate

  // active level chosen by the polarity selector
  assign want_pass = en_late ^ inv_sel;
endmodule

// File: rtl/gcb_gate_ctrl.sv
module gcb_gate_ctrl
  import gcb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic park_lvl,
  input  logic want_pass,
  output logic pass_now
);
  gate_state_e state_q;
  gate_state_e state_d;

  // the gate may only switch while the input rests at the park level
  always_comb begin
    state_d = state_q;
    if (din == park_lvl) state_d = want_pass ? GATE_OPEN : GATE_SHUT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= GATE_SHUT;
    else     state_q <= state_d;
  end

  assign pass_now = (state_d == GATE_OPEN);
endmodule

// File: rtl/gcb_out_pair.sv
module gcb_out_pair (
  input  logic clk,
  input  logic rst,
  input  logic pass,
  input  logic din,
  input  logic park_lvl,
  output logic q,
  output logic qn
);
  logic nxt;
  assign nxt = pass ? din : park_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= park_lvl;
      qn <= ~park_lvl;
    end else begin
      q  <= nxt;
      qn <= ~nxt;
    end
  end
endmodule

// File: rtl/gated_clk_buf.sv
module gated_clk_buf #(
  parameter int unsigned EN_STAGES = gcb_pkg::GCB_EN_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic en_in,
  input  logic en_inv_sel,
  input  logic park_hi,
  output logic raw_q,
  output logic raw_qn,
  output logic gate_q,
  output logic gate_qn
);
  localparam int unsigned N_PAIRS = 2;

  logic want_pass;
  logic pass_now;
  logic [N_PAIRS-1:0] pair_pass;
  logic [N_PAIRS-1:0] pair_park;
  logic [N_PAIRS-1:0] pair_q;
  logic [N_PAIRS-1:0] pair_qn;

  gcb_en_sync #(.STAGES(EN_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en_raw(en_in), .inv_sel(en_inv_sel), .want_pass(want_pass)
  );

  gcb_gate_ctrl u_ctrl (
    .clk(clk), .rst(rst), .din(din), .park_lvl(park_hi),
    .want_pass(want_pass), .pass_now(pass_now)
  );

  // pair 0: ungated, pair 1: gated
  assign pair_pass = {pass_now, 1'b1};
  assign pair_park = {park_hi, 1'b0};

  generate
    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
      gcb_out_pair u_pair (
        .clk(clk), .rst(rst), .pass(pair_pass[i]), .din(din),
        .park_lvl(pair_park[i]), .q(pair_q[i]), .qn(pair_qn[i])
      );
    end
  endgenerate

  assign raw_q   = pair_q[0];
  assign raw_qn  = pair_qn[0];
  assign gate_q  = pair_q[1];
  assign gate_qn = pair_qn[1];
endmodule

// File: rtl/gcb_chk.sv
module gcb_chk (
  input logic clk,
  input logic rst,
  input logic din,
  input logic park_hi,
  input logic raw_q,
  input logic raw_qn,
  input logic gate_q,
  input logic gate_qn
);
  // R1
  raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (raw_q == $past(din)) && (raw_qn == ~raw_q));

  // R8
  gate_compl_chk: assert property (@(posedge clk) disable iff (rst)
    gate_qn == ~gate_q);

  // R7
  full_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(gate_q) == park_hi && gate_q != park_hi)
      |-> $past(din, 2) == park_hi);

  // R6
  full_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gate_q) != park_hi && gate_q == park_hi)
      |-> $past(din) == park_hi);

  // R11
  data_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && gate_q != park_hi) |-> gate_q == raw_q);
endmodule

bind gated_clk_buf gcb_chk u_gcb_chk (
  .clk(clk), .rst(rst), .din(din), .park_hi(park_hi),
  .raw_q(raw_q), .raw_qn(raw_qn), .gate_q(gate_q), .gate_qn(gate_qn)
);

// File: tb/tb_gated_clk_buf.sv
module tb_gated_clk_buf;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0, en_in = 1'b0, en_inv_sel = 1'b0, park_hi = 1'b0;
  logic raw_q, raw_qn, gate_q, gate_qn;

  int n_chk = 0;
  int n_bad = 0;

  // expected values for the next edge
  logic e_raw, e_gate, m_open, e_rst;
  logic [ST-1:0] m_s;
  logic have_exp = 1'b0;
  int raw_run = 0, g_run = 0;

  gated_clk_buf #(.EN_STAGES(ST)) dut (
    .clk(clk), .rst(rst), .din(din), .en_in(en_in), .en_inv_sel(en_inv_sel),
    .park_hi(park_hi), .raw_q(raw_q), .raw_qn(raw_qn), .gate_q(gate_q), .gate_qn(gate_qn)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int prev_raw;
    if (!have_exp) return;
    if (e_rst) begin
      check("R10 raw_q", raw_q, 1'b0);
      check("R10 raw_qn", raw_qn, 1'b1);
      check("R10 gate_q", gate_q, park_hi);
      check("R10 gate_qn", gate_qn, ~park_hi);
      raw_run = 0;
      g_run = 0;
    end else begin
      check("R1 raw_q", raw_q, e_raw);
      check("R1 raw_qn", raw_qn, ~e_raw);
      check("R2 R3 R4 R5 R6 R7 R9 gate_q", gate_q, e_gate);
      check("R8 gate_qn", gate_qn, ~gate_q);
      prev_raw = raw_run;
      raw_run = (raw_q != park_hi) ? raw_run + 1 : 0;
      if (gate_q == park_hi && g_run > 0)
        check_int("R11 pulse width", g_run, prev_raw);
      g_run = (gate_q != park_hi) ? g_run + 1 : 0;
    end
  endtask

  // one cycle: check the last edge, drive new inputs, predict the next edge
  task automatic step(input logic r, input logic d, input logic e);
    logic want, nxt;
    @(negedge clk);
    compare();
    rst = r; din = d; en_in = e;
    e_rst = r;
    if (r) begin
      m_s = '0; m_open = 1'b0;
      e_raw = 1'b0; e_gate = park_hi;
    end else begin
      want = m_s[ST-1] ^ en_inv_sel;
      nxt = (d == park_hi) ? want : m_open;
      e_raw = d;
      e_gate = nxt ? d : park_hi;
      m_open = nxt;
      m_s = {m_s[ST-2:0], e};
    end
    have_exp = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int pk = 0; pk < 2; pk++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int hi = 1; hi <= 3; hi++) begin
          for (int lo = 1; lo <= 3; lo++) begin
            for (int ph = 0; ph < 6; ph++) begin
              park_hi = pk[0];
              en_inv_sel = pol[0];
              step(1'b1, 1'b0, 1'b0);
              step(1'b1, 1'b0, 1'b0);
              for (int c = 0; c < 48; c++) begin
                int pos;
                logic d, e;
                pos = c % (hi + lo);
                d = (pos >= lo);
                e = ((c / (5 + ph)) % 2) == 1;
                step(1'b0, d, e);
              end
            end
          end
        end
      end
    end
    // long disable then re-enable with a slow input (R9, R7)
    park_hi = 1'b0; en_inv_sel = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    for (int c = 0; c < 60; c++) step(1'b0, ((c / 4) % 2) == 1, c >= 30);
    step(1'b0, 1'b0, 1'b1);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule